// File: doc/BRIEF.md
# Status Register Write-Protect Controller

This block keeps the three protection-related bits of a serial memory's status word: a two-bit protection mode and a quad-enable flag. For each status-write attempt coming from the command logic it decides whether the write is taken. The decision uses the current mode, the write-enable latch, the active-low write-protect pin, and the quad-enable flag. It returns a one-cycle accept or reject pulse, and a pulse telling the command logic to clear its write-enable latch.

The protection mode selects one of five behaviours. Mode 00 is software protection. Mode 01 is pin-controlled protection, which is either locked or unlocked depending on the pin. Mode 10 is a lock that holds until the next power-up event. Mode 11 is a permanent lock. The quad-enable flag tells the pad logic whether the two shared pins work as write-protect and hold inputs or as data lines IO2 and IO3. While they are data lines, the protect pin carries no protect function. A power-up event and an initialize-to-default strobe model the supply cycle and the factory-default load. The retained storage behind the bits is represented by the block's own registers, and `rst_n` stands for the initial blank state.

Top module: `sr_wp_ctrl`

## Requirements
- R1: During and right after `rst_n` low, `sr_q` reads all zeros and `wr_ack`, `wr_nak`, `wel_clr` and `quad_en` are 0.
- R2: With mode bits (bit 8, bit 7) = 00, `wp_n` has no effect, and a write is accepted exactly when `wel` is 1.
- R3: With mode 01, quad-enable (bit 9) 0 and `wp_n` low, every write is rejected.
- R4: With mode 01 and either `wp_n` high or quad-enable 1, a write is accepted exactly when `wel` is 1.
- R5: With mode 10, every write is rejected. A `pwr_up` pulse returns the mode to 00 and leaves bit 9 as it was.
- R6: With mode 11, every write is rejected. The mode stays 11 through `pwr_up` and `init_def`.
- R7: An accepted write copies `wr_data[9:7]` into `sr_q[9:7]` on the clock edge that samples the request, and `wr_ack` is high for the cycle after it. A rejected write leaves `sr_q` unchanged and raises `wr_nak` for that cycle instead. All other `sr_q` bits always read 0.
- R8: `wel_clr` is high for exactly those cycles in which `wr_ack` or `wr_nak` is high.
- R9: `quad_en` equals `sr_q[9]`. A value of 1 means the shared pins are data lines IO2/IO3.
- R10: `pwr_up` outranks `init_def` and `wr_req` in the same cycle. A write that coincides with it is dropped, with no ack, no reject and no latch clear.
- R11: `init_def` without `pwr_up` clears bits 9:7 to 000 unless the mode is 11. A write in the same cycle is dropped without any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset to the blank state |
| wr_req | input | 1 | Status-write attempt, one cycle |
| wr_data | input | SR_W | Proposed status word; only bits 9:7 are used |
| wel | input | 1 | Write-enable latch state |
| wp_n | input | 1 | Write-protect pin, active low |
| pwr_up | input | 1 | Power-up event pulse |
| init_def | input | 1 | Initialize-to-default strobe |
| sr_q | output | SR_W | Current status word |
| wr_ack | output | 1 | Write accepted pulse |
| wr_nak | output | 1 | Write rejected pulse |
| wel_clr | output | 1 | Request to clear the write-enable latch |
| quad_en | output | 1 | Shared pins act as IO2/IO3 |

## Verification
The permanent lock is the hardest state to handle. Once mode 11 is written, no power-up or initialize strobe can leave it, so a random run that strays into it spends the rest of its time there. The main random phase therefore masks mode 11 out of the written data. A directed sequence walks through mode 01 with quad-enable both clear and set against a low protect pin, then mode 10 and its power-up release, then mode 11 under power-up and initialize. A final unmasked random phase is closed off by a reset.

// File: rtl/sr_wp_ctrl.sv
module sr_wp_ctrl #(
  parameter int SR_W     = 16,
  parameter int QE_POS   = 9,
  parameter int MODE_HI  = 8,
  parameter int MODE_LO  = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_req,
  input  logic [SR_W-1:0] wr_data,
  input  logic            wel,
  input  logic            wp_n,
  input  logic            pwr_up,
  input  logic            init_def,
  output logic [SR_W-1:0] sr_q,
  output logic            wr_ack,
  output logic            wr_nak,
  output logic            wel_clr,
  output logic            quad_en
);

  logic qe, m_hi, m_lo;

  wire pin_ok  = qe | wp_n;
  wire blocked = m_hi | (m_lo & ~pin_ok);
  wire take    = wr_req & ~pwr_up & ~init_def;
  wire grant   = take & wel & ~blocked;
  wire otp     = m_hi & m_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qe      <= 1'b0;
      m_hi    <= 1'b0;
      m_lo    <= 1'b0;
      wr_ack  <= 1'b0;
      wr_nak  <= 1'b0;
      wel_clr <= 1'b0;
    end else begin
      wr_ack  <= grant;
      wr_nak  <= take & ~grant;
      wel_clr <= take;
      if (pwr_up) begin
        if (m_hi & ~m_lo) begin
          m_hi <= 1'b0;
          m_lo <= 1'b0;
        end
      end else if (init_def) begin
        if (!otp) begin
          qe   <= 1'b0;
          m_hi <= 1'b0;
          m_lo <= 1'b0;
        end
      end else if (grant) begin
        qe   <= wr_data[QE_POS];
        m_hi <= wr_data[MODE_HI];
        m_lo <= wr_data[MODE_LO];
      end
    end
  end

  always_comb begin
    sr_q          = '0;
    sr_q[QE_POS]  = qe;
    sr_q[MODE_HI] = m_hi;
    sr_q[MODE_LO] = m_lo;
  end

  assign quad_en = qe;

endmodule

// File: rtl/sr_wp_ctrl_chk.sv
module sr_wp_ctrl_chk #(
  parameter int SR_W    = 16,
  parameter int QE_POS  = 9,
  parameter int MODE_HI = 8,
  parameter int MODE_LO = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_req,
  input logic            wel,
  input logic            wp_n,
  input logic            pwr_up,
  input logic            init_def,
  input logic [SR_W-1:0] sr_q,
  input logic            wr_ack,
  input logic            wr_nak,
  input logic            wel_clr,
  input logic            quad_en
);

  p_ack_nak_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ack && wr_nak));

  p_nak_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_nak |-> $stable(sr_q));

  p_welclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr == (wr_ack || wr_nak));

  p_no_wel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wel) |=> !wr_ack);

  p_pin_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !pwr_up && !init_def && !sr_q[MODE_HI] && sr_q[MODE_LO]
     && !sr_q[QE_POS] && !wp_n) |=> wr_nak);

  p_lockdown_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_up && sr_q[MODE_HI] && !sr_q[MODE_LO]) |=> (!sr_q[MODE_HI] && !sr_q[MODE_LO]));

  p_otp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_q[MODE_HI] && sr_q[MODE_LO]) |=> (sr_q[MODE_HI] && sr_q[MODE_LO]));

  p_quad_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(quad_en) |-> wr_ack);

  p_pwr_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_up |=> (!wr_ack && !wr_nak));

endmodule

bind sr_wp_ctrl sr_wp_ctrl_chk #(
  .SR_W(SR_W), .QE_POS(QE_POS), .MODE_HI(MODE_HI), .MODE_LO(MODE_LO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wel(wel), .wp_n(wp_n),
  .pwr_up(pwr_up), .init_def(init_def), .sr_q(sr_q), .wr_ack(wr_ack),
  .wr_nak(wr_nak), .wel_clr(wel_clr), .quad_en(quad_en)
);

// File: tb/sr_wp_ctrl_bench.sv
module sr_wp_ctrl_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_req = 1'b0, wel = 1'b0, wp_n = 1'b1, pwr_up = 1'b0, init_def = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] sr_q;
  logic wr_ack, wr_nak, wel_clr, quad_en;

  int checks = 0;
  int errors = 0;
  logic mq = 1'b0, mh = 1'b0, ml = 1'b0;

  always #4 clk = ~clk;

  sr_wp_ctrl u_sr_wp_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data), .wel(wel),
    .wp_n(wp_n), .pwr_up(pwr_up), .init_def(init_def), .sr_q(sr_q),
    .wr_ack(wr_ack), .wr_nak(wr_nak), .wel_clr(wel_clr), .quad_en(quad_en)
  );

  function automatic logic [W-1:0] word(input logic q, input logic h, input logic l);
    logic [W-1:0] v;
    v = '0;
    v[9] = q; v[8] = h; v[7] = l;
    return v;
  endfunction

  function automatic string tag_of(input logic pu, input logic ini, input logic wr,
                                   input logic q, input logic h, input logic l, input logic wp);
    if (pu) return (h && !l) ? "R5" : "R10";
    if (ini) return (h && l) ? "R6" : "R11";
    if (!wr) return "R7";
    case ({h, l})
      2'b00: return "R2";
      2'b01: return (!q && !wp) ? "R3" : "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check_out(input string tag, input logic [W-1:0] e_sr,
                           input logic e_ack, input logic e_nak, input logic e_wc);
    checks++;
    if (sr_q !== e_sr || wr_ack !== e_ack || wr_nak !== e_nak) begin
      errors++;
      $display("FAIL %s sr/ack/nak actual %h/%b/%b expected %h/%b/%b",
               tag, sr_q, wr_ack, wr_nak, e_sr, e_ack, e_nak);
    end
    checks++;
    if (wel_clr !== e_wc) begin
      errors++;
      $display("FAIL R8 wel_clr actual %b expected %b", wel_clr, e_wc);
    end
    checks++;
    if (quad_en !== e_sr[9]) begin
      errors++;
      $display("FAIL R9 quad_en actual %b expected %b", quad_en, e_sr[9]);
    end
  endtask

  task automatic step(input logic wr, input logic [W-1:0] d, input logic we,
                      input logic wp, input logic pu, input logic ini);
    logic take, blk, ok;
    string tag;
    wr_req = wr; wr_data = d; wel = we; wp_n = wp; pwr_up = pu; init_def = ini;
    tag  = tag_of(pu, ini, wr, mq, mh, ml, wp);
    take = wr && !pu && !ini;
    blk  = mh || (ml && !(mq || wp));
    ok   = take && we && !blk;
    if (pu) begin
      if (mh && !ml) begin mh = 1'b0; ml = 1'b0; end
    end else if (ini) begin
      if (!(mh && ml)) begin mq = 1'b0; mh = 1'b0; ml = 1'b0; end
    end else if (ok) begin
      mq = d[9]; mh = d[8]; ml = d[7];
    end
    @(posedge clk);
    @(negedge clk);
    check_out(tag, word(mq, mh, ml), ok, take && !ok, take);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; wr_req = 1'b0; pwr_up = 1'b0; init_def = 1'b0;
    repeat (2) @(negedge clk);
    check_out("R1", '0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    mq = 1'b0; mh = 1'b0; ml = 1'b0;
    @(negedge clk);
    check_out("R1", '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic rand_step(input bit allow_otp);
    logic [W-1:0] d;
    d = W'($urandom);
    if (!allow_otp && d[8] && d[7]) d[7] = 1'b0;
    step($urandom_range(0, 1) == 1, d, $urandom_range(0, 3) != 0,
         $urandom_range(0, 1) == 1, $urandom_range(0, 15) == 0,
         $urandom_range(0, 31) == 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_abcd));
    do_reset();

    // directed corners
    step(1, word(0, 0, 1), 1, 0, 0, 0);  // R2: pin low ignored in mode 00
    step(1, word(0, 0, 0), 1, 0, 0, 0);  // R3: locked by pin
    step(1, word(1, 0, 1), 1, 1, 0, 0);  // R4: pin high
    step(1, word(1, 0, 1), 1, 0, 0, 0);  // R4: quad set, pin function gone
    step(1, word(0, 0, 0), 0, 1, 0, 0);  // R4: no latch
    step(1, word(1, 1, 0), 1, 1, 0, 0);  // enter mode 10
    step(1, word(0, 0, 0), 1, 1, 0, 0);  // R5: rejected
    step(0, '0, 0, 1, 0, 1);             // R11 not locked? mode 10 clears
    step(1, word(1, 1, 0), 1, 1, 0, 0);  // back to 10 with quad
    step(1, word(0, 0, 0), 1, 1, 1, 0);  // R10/R5: power-up wins, releases
    step(1, word(0, 0, 0), 1, 1, 0, 1);  // R11: init wins over write
    step(1, {W{1'b1}}, 1, 1, 0, 0);      // R7: other bits read 0, enter 11
    step(0, '0, 0, 1, 1, 0);             // R6: power-up
    step(0, '0, 0, 1, 0, 1);             // R6: init
    step(1, word(0, 0, 0), 1, 1, 0, 0);  // R6: rejected
    do_reset();

    for (int i = 0; i < 4000; i++) rand_step(1'b0);
    for (int i = 0; i < 800; i++) rand_step(1'b1);
    do_reset();
    for (int i = 0; i < 400; i++) rand_step(1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule